// File: doc/BRIEF.md
# Test Access Hub for Mesh Boundary Routers

The test access hub sits at the edge of a mesh network and joins one external tester to a set of boundary routers that serve as test entry points. Stimulus packets from the tester arrive on a single input stream and are steered to one router input, chosen by a configuration register. Response packets leave the routers on several output streams. They compete for the single return stream to the tester, and a round-robin arbiter decides which one is carried.

A run-time enable mask picks which boundary routers take part in testing. This allows a reduced setup, for example two access points per mesh side instead of four, without changing the hardware. Every stream uses valid/ready handshaking, and a last-flit flag marks the end of each packet. The configuration can only change between packets, so a packet is never split across two settings.

Top module: `test_access_hub`

## Requirements
- R1: After reset the enable mask reads all ones, the destination select reads 0, no router input is driven valid and the tester output is not valid.
- R2: A stimulus flit is presented, with unchanged data and last flag, on exactly the router input numbered by the destination select. No other router input sees valid.
- R3: The destination is taken at the first flit of a packet and kept until that packet's last flit has been accepted.
- R4: The tester-in ready equals the ready of the addressed router input when that input is enabled in the mask.
- R5: When the addressed router input is disabled in the mask, stimulus flits are accepted (ready high) and discarded. No router input sees valid.
- R6: The tester output carries the data and last flag of exactly one granted router output. Only that output sees ready, and only while the tester output is ready.
- R7: Arbitration is round-robin. After a packet from output g completes, the search for the next grant starts at g+1, wrapping from the highest index to 0. The first search after reset starts at 0.
- R8: Once the first flit of a multi-flit response is accepted, the grant stays on that output until its last flit is accepted, even when other outputs request.
- R9: Router outputs disabled in the mask never receive ready and are never forwarded, even when they assert valid.
- R10: A configuration write while no packet is in flight sets the mask and destination select, which read back the new values from the next cycle.
- R11: A configuration write while a stimulus or response packet is mid-transfer is ignored, and both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wmask | input | N | New enable mask (bit i enables access point i) |
| cfg_wsel | input | SEL_W | New stimulus destination index |
| cfg_mask | output | N | Current enable mask |
| cfg_sel | output | SEL_W | Current stimulus destination index |
| tin_valid | input | 1 | Tester stimulus flit valid |
| tin_data | input | W | Tester stimulus flit data |
| tin_last | input | 1 | Tester stimulus last flit |
| tin_ready | output | 1 | Tester stimulus ready |
| rin_valid | output | N | Valid toward each router input |
| rin_data | output | N*W | Flit data toward router inputs, lane i at bits i*W |
| rin_last | output | N | Last flag toward router inputs |
| rin_ready | input | N | Ready from each router input |
| rout_valid | input | N | Valid from each router output |
| rout_data | input | N*W | Flit data from router outputs, lane i at bits i*W |
| rout_last | input | N | Last flag from router outputs |
| rout_ready | output | N | Ready toward each router output |
| tout_valid | output | 1 | Response flit valid toward tester |
| tout_data | output | W | Response flit data toward tester |
| tout_last | output | 1 | Response last flit toward tester |
| tout_ready | input | 1 | Tester response ready |

## Verification
The bench builds the hub with N = 4 access points and 16-bit flits. Four points let the round-robin pointer wrap from index 3 back to 0 within a few packets, and they let masks with disabled points on both sides of the selected index be tried quickly. A table of mask, destination and router-ready patterns covers steering, backpressure and discard. Directed sequences then cover held grants across multi-flit responses, the wrap-around, masked requesters, and configuration writes attempted during stimulus and response packets.

// File: rtl/hub_pkg.sv
package hub_pkg;

  // advance a port index by one with wrap to zero
  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // add an offset to a port index modulo n (offset < n)
  function automatic int unsigned wrap_add(input int unsigned idx, input int unsigned off,
                                           input int unsigned n);
    int unsigned s;
    s = idx + off;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/hub_cfg_regs.sv
module hub_cfg_regs #(
  parameter int N     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [N-1:0]     wmask,
  input  logic [SEL_W-1:0] wsel,
  input  logic             busy,
  output logic [N-1:0]     mask_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             wr_taken
);

  assign wr_taken = we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sel_q  <= '0;
    end else if (wr_taken) begin
      mask_q <= wmask;
      sel_q  <= wsel;
    end
  end

endmodule

// File: rtl/hub_stim_steer.sv
module hub_stim_steer #(
  parameter int N     = 8,
  parameter int W     = 32,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     mask,
  input  logic [SEL_W-1:0] sel,
  input  logic             tin_valid,
  input  logic [W-1:0]     tin_data,
  input  logic             tin_last,
  output logic             tin_ready,
  output logic [N-1:0]     rin_valid,
  output logic [N*W-1:0]   rin_data,
  output logic [N-1:0]     rin_last,
  input  logic [N-1:0]     rin_ready,
  output logic             busy,
  output logic [SEL_W-1:0] dest
);

  logic             mid_q;
  logic [SEL_W-1:0] dest_q;
  logic             dest_on;
  logic             fire;

  assign dest    = mid_q ? dest_q : sel;
  assign dest_on = mask[dest];
  assign tin_ready = dest_on ? rin_ready[dest] : 1'b1;
  assign fire    = tin_valid && tin_ready;
  assign busy    = mid_q;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign rin_valid[i]         = tin_valid && dest_on && (dest == SEL_W'(i));
    assign rin_data[i*W +: W]   = tin_data;
    assign rin_last[i]          = tin_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q  <= 1'b0;
      dest_q <= '0;
    end else if (fire) begin
      mid_q  <= !tin_last;
      dest_q <= dest;
    end
  end

endmodule

// File: rtl/hub_resp_arb.sv
module hub_resp_arb #(
  parameter int N     = 8,
  parameter int W     = 32,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     rout_valid,
  input  logic [N*W-1:0]   rout_data,
  input  logic [N-1:0]     rout_last,
  output logic [N-1:0]     rout_ready,
  output logic             tout_valid,
  output logic [W-1:0]     tout_data,
  output logic             tout_last,
  input  logic             tout_ready,
  output logic             busy,
  output logic [SEL_W-1:0] cur
);
  import hub_pkg::*;

  logic [N-1:0]     req;
  logic [SEL_W-1:0] ptr_q;
  logic [SEL_W-1:0] gnt_q;
  logic             lock_q;
  logic [SEL_W-1:0] pick;
  logic             fire;
  logic             live;

  // first requester at or after the pointer, wrapping
  function automatic logic [SEL_W-1:0] rr_pick(input logic [N-1:0] r, input logic [SEL_W-1:0] p);
    logic [SEL_W-1:0] res;
    logic             found;
    int unsigned      idx;
    res   = p;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = wrap_add(int'(p), k, N);
      if (!found && r[idx]) begin
        res   = SEL_W'(idx);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  assign req  = rout_valid & mask;
  assign pick = rr_pick(req, ptr_q);
  assign cur  = lock_q ? gnt_q : pick;
  assign live = lock_q || (|req);
  assign tout_valid = lock_q ? rout_valid[gnt_q] : (|req);
  assign tout_data  = rout_data[cur*W +: W];
  assign tout_last  = rout_last[cur];
  assign fire = tout_valid && tout_ready;
  assign busy = lock_q;

  for (genvar i = 0; i < N; i++) begin : g_rdy
    assign rout_ready[i] = live && tout_ready && (cur == SEL_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      gnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (fire) begin
      if (tout_last) begin
        lock_q <= 1'b0;
        ptr_q  <= SEL_W'(wrap_next(int'(cur), N));
      end else begin
        lock_q <= 1'b1;
        gnt_q  <= cur;
      end
    end
  end

endmodule

// File: rtl/test_access_hub.sv
module test_access_hub #(
  parameter int N     = 8,
  parameter int W     = 32,
  parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [N-1:0]     cfg_wmask,
  input  logic [SEL_W-1:0] cfg_wsel,
  output logic [N-1:0]     cfg_mask,
  output logic [SEL_W-1:0] cfg_sel,
  input  logic             tin_valid,
  input  logic [W-1:0]     tin_data,
  input  logic             tin_last,
  output logic             tin_ready,
  output logic [N-1:0]     rin_valid,
  output logic [N*W-1:0]   rin_data,
  output logic [N-1:0]     rin_last,
  input  logic [N-1:0]     rin_ready,
  input  logic [N-1:0]     rout_valid,
  input  logic [N*W-1:0]   rout_data,
  input  logic [N-1:0]     rout_last,
  output logic [N-1:0]     rout_ready,
  output logic             tout_valid,
  output logic [W-1:0]     tout_data,
  output logic             tout_last,
  input  logic             tout_ready
);

  logic             stim_busy;
  logic             resp_busy;
  logic             all_busy;
  logic             cfg_taken;
  logic [SEL_W-1:0] stim_dest;
  logic [SEL_W-1:0] resp_idx;

  assign all_busy = stim_busy || resp_busy;

  hub_cfg_regs #(.N(N), .SEL_W(SEL_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wmask(cfg_wmask), .wsel(cfg_wsel),
    .busy(all_busy), .mask_q(cfg_mask), .sel_q(cfg_sel), .wr_taken(cfg_taken)
  );

  hub_stim_steer #(.N(N), .W(W), .SEL_W(SEL_W)) stim_i (
    .clk(clk), .rst_n(rst_n), .mask(cfg_mask), .sel(cfg_sel),
    .tin_valid(tin_valid), .tin_data(tin_data), .tin_last(tin_last), .tin_ready(tin_ready),
    .rin_valid(rin_valid), .rin_data(rin_data), .rin_last(rin_last), .rin_ready(rin_ready),
    .busy(stim_busy), .dest(stim_dest)
  );

  hub_resp_arb #(.N(N), .W(W), .SEL_W(SEL_W)) resp_i (
    .clk(clk), .rst_n(rst_n), .mask(cfg_mask),
    .rout_valid(rout_valid), .rout_data(rout_data), .rout_last(rout_last), .rout_ready(rout_ready),
    .tout_valid(tout_valid), .tout_data(tout_data), .tout_last(tout_last), .tout_ready(tout_ready),
    .busy(resp_busy), .cur(resp_idx)
  );

endmodule

// File: rtl/hub_checker.sv
module hub_checker #(
  parameter int N     = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [N-1:0]     cfg_wmask,
  input logic [SEL_W-1:0] cfg_wsel,
  input logic [N-1:0]     cfg_mask,
  input logic [SEL_W-1:0] cfg_sel,
  input logic             tin_valid,
  input logic             tin_ready,
  input logic             tin_last,
  input logic [N-1:0]     rin_valid,
  input logic [N-1:0]     rin_ready,
  input logic [N-1:0]     rout_ready,
  input logic             tout_valid,
  input logic             tout_ready,
  input logic             tout_last,
  input logic             stim_busy,
  input logic             resp_busy,
  input logic             all_busy,
  input logic [SEL_W-1:0] stim_dest,
  input logic [SEL_W-1:0] resp_idx
);

  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rin_valid));

  a_r3_dest_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stim_busy && !(tin_valid && tin_ready && tin_last) |=> stim_dest == $past(stim_dest));

  a_r4_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rin_valid & rin_ready)) |-> tin_ready);

  a_r6_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rout_ready));

  a_r8_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resp_busy && !(tout_valid && tout_ready && tout_last) |=> resp_idx == $past(resp_idx));

  a_r9_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rout_ready & ~cfg_mask) == '0);

  a_r10_cfg_take: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !all_busy |=> cfg_mask == $past(cfg_wmask) && cfg_sel == $past(cfg_wsel));

  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && all_busy |=> $stable(cfg_mask) && $stable(cfg_sel));

endmodule

bind test_access_hub hub_checker #(.N(N), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wmask(cfg_wmask), .cfg_wsel(cfg_wsel),
  .cfg_mask(cfg_mask), .cfg_sel(cfg_sel), .tin_valid(tin_valid), .tin_ready(tin_ready),
  .tin_last(tin_last), .rin_valid(rin_valid), .rin_ready(rin_ready), .rout_ready(rout_ready),
  .tout_valid(tout_valid), .tout_ready(tout_ready), .tout_last(tout_last),
  .stim_busy(stim_busy), .resp_busy(resp_busy), .all_busy(all_busy),
  .stim_dest(stim_dest), .resp_idx(resp_idx)
);

// File: tb/test_access_hub_tb.sv
module test_access_hub_tb_top;
  localparam int N = 4;
  localparam int W = 16;
  localparam int SEL_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [N-1:0] cfg_wmask = '0;
  logic [SEL_W-1:0] cfg_wsel = '0;
  logic [N-1:0] cfg_mask;
  logic [SEL_W-1:0] cfg_sel;
  logic tin_valid = 1'b0;
  logic [W-1:0] tin_data = '0;
  logic tin_last = 1'b0;
  logic tin_ready;
  logic [N-1:0] rin_valid;
  logic [N*W-1:0] rin_data;
  logic [N-1:0] rin_last;
  logic [N-1:0] rin_ready = '0;
  logic [N-1:0] rout_valid = '0;
  logic [N*W-1:0] rout_data = '0;
  logic [N-1:0] rout_last = '0;
  logic [N-1:0] rout_ready;
  logic tout_valid;
  logic [W-1:0] tout_data;
  logic tout_last;
  logic tout_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  test_access_hub #(.N(N), .W(W), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wmask(cfg_wmask), .cfg_wsel(cfg_wsel),
    .cfg_mask(cfg_mask), .cfg_sel(cfg_sel), .tin_valid(tin_valid), .tin_data(tin_data),
    .tin_last(tin_last), .tin_ready(tin_ready), .rin_valid(rin_valid), .rin_data(rin_data),
    .rin_last(rin_last), .rin_ready(rin_ready), .rout_valid(rout_valid), .rout_data(rout_data),
    .rout_last(rout_last), .rout_ready(rout_ready), .tout_valid(tout_valid),
    .tout_data(tout_data), .tout_last(tout_last), .tout_ready(tout_ready)
  );

  // steering vectors: mask, sel, rin_ready, expected rin_valid, expected tin_ready
  typedef struct packed {
    logic [3:0] mask;
    logic [1:0] sel;
    logic [3:0] rrdy;
    logic [3:0] exp_v;
    logic       exp_r;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'b1111, 2'd0, 4'b1111, 4'b0001, 1'b1},
    '{4'b1111, 2'd2, 4'b1011, 4'b0100, 1'b0},
    '{4'b1111, 2'd3, 4'b1000, 4'b1000, 1'b1},
    '{4'b1011, 2'd2, 4'b1111, 4'b0000, 1'b1},
    '{4'b0110, 2'd1, 4'b0000, 4'b0010, 1'b0},
    '{4'b0110, 2'd3, 4'b1111, 4'b0000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [N-1:0] m, input logic [SEL_W-1:0] s);
    cfg_we = 1'b1; cfg_wmask = m; cfg_wsel = s;
    tick();
    cfg_we = 1'b0;
  endtask

  function automatic logic [W-1:0] rflit(input int p, input int f);
    return W'(p * 16 + f);
  endfunction

  task automatic set_rout(input int p, input logic v, input int f, input logic l);
    rout_valid[p] = v;
    rout_data[p*W +: W] = rflit(p, f);
    rout_last[p] = l;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #12;
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 mask", 32'(cfg_mask), 32'hF);
    check("R1 sel", 32'(cfg_sel), 0);
    check("R1 rin_valid", 32'(rin_valid), 0);
    check("R1 tout_valid", 32'(tout_valid), 0);

    // table walk: R2 steering, R4 backpressure, R5 discard, R10 config write
    foreach (VECS[k]) begin
      write_cfg(VECS[k].mask, VECS[k].sel);
      check("R10 mask readback", 32'(cfg_mask), 32'(VECS[k].mask));
      check("R10 sel readback", 32'(cfg_sel), 32'(VECS[k].sel));
      rin_ready = VECS[k].rrdy;
      tin_valid = 1'b1; tin_last = 1'b1; tin_data = W'(16'hA000 + k);
      #1;
      check("R2 R5 rin_valid", 32'(rin_valid), 32'(VECS[k].exp_v));
      check("R4 R5 tin_ready", 32'(tin_ready), 32'(VECS[k].exp_r));
      if (VECS[k].exp_v != 0) begin
        check("R2 data", 32'(rin_data[VECS[k].sel*W +: W]), 32'(16'hA000 + k));
        check("R2 last", 32'(rin_last[VECS[k].sel]), 1);
      end
      tick();
      tin_valid = 1'b0;
    end

    // R3 and R11: multi-flit stimulus with write attempt mid-packet
    write_cfg(4'b1111, 2'd1);
    rin_ready = 4'b1111;
    tin_valid = 1'b1; tin_last = 1'b0; tin_data = 16'hB000;
    tick();
    cfg_we = 1'b1; cfg_wmask = 4'b0001; cfg_wsel = 2'd2;
    tin_data = 16'hB001;
    #1;
    check("R3 dest held flit1", 32'(rin_valid), 32'b0010);
    tick();
    cfg_we = 1'b0;
    check("R11 sel kept during stimulus", 32'(cfg_sel), 1);
    check("R11 mask kept during stimulus", 32'(cfg_mask), 32'hF);
    tin_last = 1'b1; tin_data = 16'hB002;
    #1;
    check("R3 dest held last", 32'(rin_valid), 32'b0010);
    check("R3 data", 32'(rin_data[1*W +: W]), 32'hB002);
    tick();
    tin_valid = 1'b0; tin_last = 1'b0;

    // responses: pointer at 0 after reset
    tout_ready = 1'b1;
    set_rout(1, 1, 0, 0);
    set_rout(3, 1, 0, 1);
    #1;
    check("R7 first grant", 32'(tout_data), 32'(rflit(1, 0)));
    check("R6 ready one-hot", 32'(rout_ready), 32'b0010);
    check("R6 last", 32'(tout_last), 0);
    tick();
    // locked on 1; port 0 joins; write attempt during response
    set_rout(1, 1, 1, 1);
    set_rout(0, 1, 0, 1);
    cfg_we = 1'b1; cfg_wmask = 4'b0011; cfg_wsel = 2'd3;
    #1;
    check("R8 grant held", 32'(tout_data), 32'(rflit(1, 1)));
    check("R8 ready held", 32'(rout_ready), 32'b0010);
    tick();
    cfg_we = 1'b0;
    check("R11 mask kept during response", 32'(cfg_mask), 32'hF);
    check("R11 sel kept during response", 32'(cfg_sel), 1);
    set_rout(1, 0, 0, 0);
    #1;
    check("R7 next after 1", 32'(tout_data), 32'(rflit(3, 0)));
    check("R6 ready port3", 32'(rout_ready), 32'b1000);
    // backpressure from tester
    tout_ready = 1'b0;
    #1;
    check("R6 no ready when stalled", 32'(rout_ready), 0);
    check("R6 valid while stalled", 32'(tout_valid), 1);
    tout_ready = 1'b1;
    tick();
    set_rout(3, 0, 0, 0);
    set_rout(1, 1, 2, 1);
    #1;
    check("R7 wrap to 0", 32'(tout_data), 32'(rflit(0, 0)));
    tick();
    set_rout(0, 0, 0, 0);
    set_rout(1, 0, 0, 0);
    // R9: disable port 0, request only from it
    write_cfg(4'b1110, 2'd1);
    set_rout(0, 1, 5, 1);
    #1;
    check("R9 masked not forwarded", 32'(tout_valid), 0);
    check("R9 masked no ready", 32'(rout_ready), 0);
    tick();
    set_rout(2, 1, 0, 1);
    #1;
    check("R9 masked skipped", 32'(tout_data), 32'(rflit(2, 0)));
    check("R9 ready only enabled", 32'(rout_ready), 32'b0100);
    tick();
    set_rout(2, 0, 0, 0);
    set_rout(0, 0, 0, 0);
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule